// File: doc/BRIEF.md
# Flag-Setting Adder with Branch-Condition Evaluator

This block is a 32-bit add/subtract unit that keeps four status flags: negative, zero, carry and overflow. Next to it sits an evaluator that turns a 4-bit condition code and the stored flags into a single taken/not-taken signal. Each clock cycle the unit performs one of four operations: add, add-with-carry, subtract or compare. It writes the result register for every operation except compare. It writes the flags when set-flags is high, and it always writes them on compare.

Subtraction is formed as A + ~B + 1. The carry flag after a subtract or compare is therefore the adder's carry out, which means "no borrow". Comparing 5 with 10 leaves carry clear. The unsigned higher and lower-or-same conditions read this raw carry with no correction for whether the last flag-setting operation was an add or a subtract. After an add they can therefore disagree with the arithmetic meaning, and this is intended behaviour.

Top module: `flag_alu`

## Requirements
- R1: With op = 00 (add), the result register takes A + B modulo 2^32, and C takes the carry out of bit 31. For example, 5 + 10 leaves C = 0.
- R2: With op = 10 (subtract), the result takes A - B. C is 1 when A >= B unsigned (no borrow) and 0 when the subtraction borrows.
- R3: With op = 11 (compare), the flags are updated as for a subtract whatever set_flags is, and the result register keeps its previous value.
- R4: With op = 01 (add-with-carry), the result is A + B + C, where C is the stored carry flag before the clock edge.
- R5: When set_flags is 0 and op is not compare, all four flags keep their values across the clock edge.
- R6: flags is packed {N,Z,C,V} in bits 3..0. N takes bit 31 of the computed sum and Z is 1 exactly when all 32 bits of the sum are zero, for add and subtract alike.
- R7: V is set when both effective operands (B inverted for subtract) share a sign and the sum's sign differs from it.
- R8: cond codes 0000 EQ (Z), 0001 NE (!Z), 0010 CS (C), 0011 CC (!C), 0100 MI (N), 0101 PL (!N), 0110 VS (V), 0111 VC (!V), 1010 GE (N==V), 1011 LT (N!=V), 1100 GT (!Z and N==V), 1101 LE (Z or N!=V) drive cond_true combinationally from the stored flags.
- R9: cond 1000 (HI) is true when C = 1 and Z = 0, and cond 1001 (LS) is true when C = 0 or Z = 1, using the stored carry as it is.
- R10: cond 1110 is always true and cond 1111 is never true.
- R11: While rst_n is low, the result and all flags are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 2 | 00 add, 01 add-with-carry, 10 subtract, 11 compare |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| set_flags | input | 1 | Update flags on this edge (compare updates regardless) |
| cond | input | 4 | Condition code to evaluate |
| result | output | 32 | Registered arithmetic result |
| flags | output | 4 | Registered {N,Z,C,V} |
| cond_true | output | 1 | Condition evaluation of cond against flags |

## Verification
The bench goes after the carry polarity on subtraction. A design that stored borrow instead of not-borrow would set C when comparing 5 with 10 and would flip every HI/LS and CS/CC answer that follows. The bench wraps 0xFFFFFFFF + 1 to zero and adds 1 to 0x7FFFFFFF to reach both zero-with-carry and signed overflow. A wrong overflow rule would then show up as a bad V, GE or LT answer. Add-with-carry runs with the stored carry both set and clear, so a design that ignored it or fed it in inverted would return an off-by-one sum. Compare and flag-hold cycles then check that a design writing the result on compare, or the flags without set_flags, shows changed values at the ports.

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         set_flags,
  input  logic [3:0]   cond,
  output logic [W-1:0] result,
  output logic [3:0]   flags,
  output logic         cond_true
);

  localparam logic [1:0] OP_ADD = 2'b00;
  localparam logic [1:0] OP_ADC = 2'b01;
  localparam logic [1:0] OP_SUB = 2'b10;
  localparam logic [1:0] OP_CMP = 2'b11;

  logic         is_sub;
  logic         cin;
  logic [W-1:0] b_eff;
  logic [W:0]   sum;
  logic         n_new, z_new, c_new, v_new;
  logic         fn, fz, fc, fv;

  assign is_sub = (op == OP_SUB) || (op == OP_CMP);
  assign b_eff  = is_sub ? ~b : b;
  assign cin    = is_sub | ((op == OP_ADC) & fc);
  assign sum    = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};

  assign n_new = sum[W-1];
  assign z_new = (sum[W-1:0] == '0);
  assign c_new = sum[W];
  assign v_new = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      flags  <= 4'b0000;
    end else begin
      if (op != OP_CMP)
        result <= sum[W-1:0];
      if (set_flags || op == OP_CMP)
        flags <= {n_new, z_new, c_new, v_new};
    end
  end

  assign {fn, fz, fc, fv} = flags;

  always_comb begin
    unique case (cond)
      4'h0: cond_true = fz;
      4'h1: cond_true = !fz;
      4'h2: cond_true = fc;
      4'h3: cond_true = !fc;
      4'h4: cond_true = fn;
      4'h5: cond_true = !fn;
      4'h6: cond_true = fv;
      4'h7: cond_true = !fv;
      4'h8: cond_true = fc && !fz;
      4'h9: cond_true = !fc || fz;
      4'hA: cond_true = (fn == fv);
      4'hB: cond_true = (fn != fv);
      4'hC: cond_true = !fz && (fn == fv);
      4'hD: cond_true = fz || (fn != fv);
      4'hE: cond_true = 1'b1;
      default: cond_true = 1'b0;
    endcase
  end

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  op,
  input logic [31:0] a,
  input logic [31:0] b,
  input logic        set_flags,
  input logic [3:0]  cond,
  input logic [31:0] result,
  input logic [3:0]  flags,
  input logic        cond_true
);

  assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_flags && op != 2'b11) |=> $stable(flags));

  assert_cmp_keeps_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'b11) |=> $stable(result));

  assert_sub_not_borrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'b10 && set_flags) |=> (flags[1] == ($past(a) >= $past(b))));

  assert_nz_track_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && op != 2'b11) |=> (flags[3] == result[31]) && (flags[2] == (result == 32'd0)));

  assert_never_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 4'hF) |-> !cond_true);

  assert_always_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 4'hE) |-> cond_true);

  assert_hi_raw_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 4'h8 && cond_true) |-> (flags[1] && !flags[2]));

endmodule

bind flag_alu flag_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .a(a), .b(b), .set_flags(set_flags),
  .cond(cond), .result(result), .flags(flags), .cond_true(cond_true)
);

// File: tb/tb_flag_alu.sv
`timescale 1ns/100ps
module tb_flag_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] a = '0, b = '0;
  logic        set_flags = 1'b0;
  logic [3:0]  cond = 4'h0;
  logic [31:0] result;
  logic [3:0]  flags;
  logic        cond_true;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  flag_alu dut (.clk(clk), .rst_n(rst_n), .op(op), .a(a), .b(b), .set_flags(set_flags),
                .cond(cond), .result(result), .flags(flags), .cond_true(cond_true));

  always #2 clk = ~clk;

  // {op, a, b, set_flags, expected result, expected NZCV}
  localparam int NV = 13;
  localparam logic [102:0] VEC [NV] = '{
    {2'b00, 32'd5,          32'd10,         1'b1, 32'd15,         4'b0000}, // R1 5+10 no carry
    {2'b10, 32'd5,          32'd10,         1'b1, 32'hFFFFFFFB,   4'b1000}, // R2 borrow -> C=0
    {2'b11, 32'd10,         32'd5,          1'b0, 32'hFFFFFFFB,   4'b0010}, // R3 cmp no borrow
    {2'b01, 32'd1,          32'd2,          1'b1, 32'd4,          4'b0000}, // R4 C=1 used
    {2'b00, 32'hFFFFFFFF,   32'd1,          1'b1, 32'd0,          4'b0110}, // R1 R6 wrap
    {2'b01, 32'd0,          32'd0,          1'b0, 32'd1,          4'b0110}, // R4 R5
    {2'b00, 32'h7FFFFFFF,   32'd1,          1'b1, 32'h80000000,   4'b1001}, // R7 pos overflow
    {2'b10, 32'h80000000,   32'd1,          1'b1, 32'h7FFFFFFF,   4'b0011}, // R7 neg overflow
    {2'b11, 32'd0,          32'd0,          1'b1, 32'h7FFFFFFF,   4'b0110}, // R3 equal
    {2'b10, 32'd3,          32'd3,          1'b0, 32'd0,          4'b0110}, // R5 hold
    {2'b01, 32'hFFFFFFFF,   32'd0,          1'b1, 32'd0,          4'b0110}, // R4 carry chain
    {2'b11, 32'd1,          32'd2,          1'b0, 32'd0,          4'b1000}, // R3 R2 borrow
    {2'b00, 32'h80000000,   32'h80000000,   1'b1, 32'd0,          4'b0111}  // R7 R1
  };

  function automatic logic cond_ref(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'h0: return z;       4'h1: return !z;
      4'h2: return cy;      4'h3: return !cy;
      4'h4: return n;       4'h5: return !n;
      4'h6: return v;       4'h7: return !v;
      4'h8: return cy & !z; 4'h9: return !cy | z;
      4'hA: return n ~^ v;  4'hB: return n ^ v;
      4'hC: return !z & (n ~^ v);
      4'hD: return z | (n ^ v);
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sweep_conds(input logic [3:0] f);
    for (int c = 0; c < 16; c++) begin
      cond = c[3:0];
      #0.1;
      if (c == 8 || c == 9) check("R9 cond", {31'd0, cond_true}, {31'd0, cond_ref(c[3:0], f)});
      else if (c >= 14)     check("R10 cond", {31'd0, cond_true}, {31'd0, cond_ref(c[3:0], f)});
      else                  check("R8 cond", {31'd0, cond_true}, {31'd0, cond_ref(c[3:0], f)});
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 result", result, 32'd0);
    check("R11 flags", {28'd0, flags}, 32'd0);
    sweep_conds(4'b0000);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [102:0] v;
      v = VEC[i];
      op = v[102:101]; a = v[100:69]; b = v[68:37]; set_flags = v[36];
      @(negedge clk);
      check($sformatf("R1-4 vec%0d result", i), result, v[35:4]);
      check($sformatf("R6 R7 vec%0d flags", i), {28'd0, flags}, {28'd0, v[3:0]});
      // idle: add result+0 without flags, keeps result unchanged
      op = 2'b00; a = v[35:4]; b = 32'd0; set_flags = 1'b0;
      sweep_conds(v[3:0]);
      @(negedge clk);
    end

    // R9: HI/LS after an add read the raw carry (5+10 leaves C=0, so LS taken)
    op = 2'b00; a = 32'd5; b = 32'd10; set_flags = 1'b1;
    @(negedge clk);
    set_flags = 1'b0; a = 32'd15; b = 32'd0;
    cond = 4'h9; #0.1;
    check("R9 LS after add", {31'd0, cond_true}, 32'd1);
    cond = 4'h8; #0.1;
    check("R9 HI after add", {31'd0, cond_true}, 32'd0);

    // R2: cmp 5 with 10 clears carry -> CC taken
    op = 2'b11; a = 32'd5; b = 32'd10;
    @(negedge clk);
    op = 2'b00; a = 32'd15;
    cond = 4'h3; #0.1;
    check("R2 cmp 5,10 C clear", {28'd0, flags}, 32'h8);
    check("R2 CC taken", {31'd0, cond_true}, 32'd1);

    // R11: reset mid-run clears state
    op = 2'b00; a = 32'hFFFFFFFF; b = 32'd1; set_flags = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    check("R11 async result", result, 32'd0);
    check("R11 async flags", {28'd0, flags}, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule